// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outgoing path of a host bridge. It turns a narrow local bus address into a wide remote address. The local region starts at a fixed base. Above that base the region is cut into a parameterised number of windows, all the same size and laid end to end. Each window carries its own 64-bit remote base, split into a low word and a high word, and its own enable bit, which is bit 0 of the low word. A single size code sets the window size for all windows, as a power of two in megabytes. A control word holds a global translation enable and, next to it, a link-training enable bit that is passed straight to the link logic.

A local address that falls in an enabled window is rebased. The result is the window's remote base with bit 0 cleared, plus the address's offset inside the window. An address that misses raises a flag and leaves the block unchanged, zero-extended to 64 bits. That covers addresses below the region, past the last window, or in a disabled window. With translation switched off, every address passes through unchanged and no miss is ever flagged. Software programs the block through a simple register write port with a combinational read-back. The translated result appears one clock after the request.

Top module: `ob_win_xlate`

## Requirements
- R1: After reset, `out_valid`, `ctl_link_train` and `ctl_xlat_en` are 0, the size register reads 3 (8 MB windows), and the control register and every window register read 0.
- R2: The low base word of window n is at register offset 0x200+8n and the high word is at 0x204+8n. Each reads back the full 32-bit value last written to it.
- R3: The control register is at offset 0x004. Bit 0 drives `ctl_link_train` and bit 1 is the translation enable driving `ctl_xlat_en`. Only these two bits are stored; the other bits read as 0.
- R4: The size register is at offset 0x010. It stores bits [2:0] as code c, which gives windows of 2^c MB; its other bits read as 0. Unmapped offsets read as 0.
- R5: With translation on, an address A at or above REGION_BASE selects window index (A-REGION_BASE) >> (20+c). If that window exists and its low word has bit 0 set, `out_addr` = {high, low with bit 0 cleared} + ((A-REGION_BASE) mod 2^(20+c)) and `out_miss` = 0.
- R6: With translation on, an address that selects a window whose enable bit is 0 gives `out_miss` = 1, and `out_addr` is A zero-extended.
- R7: With translation on, an address below REGION_BASE, or one whose window index is NUM_WIN or larger, gives `out_miss` = 1 and `out_addr` is A zero-extended.
- R8: With translation off, `out_addr` is A zero-extended and `out_miss` = 0 for every address, including ones outside the region.
- R9: `out_valid` follows `lcl_valid` one clock later. `out_addr` and `out_miss` belong to the request sampled at that earlier edge.
- R10: The offset is added across the full 64 bits, so a carry out of the low word increments the high word.
- R11: A new size code takes effect on the next request. It changes both which window an address selects and the width of the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| lcl_valid | input | 1 | Local request valid |
| lcl_addr | input | LA_W | Local address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_addr | output | 64 | Translated or pass-through remote address |
| out_miss | output | 1 | Translation enabled but no enabled window matched |
| ctl_link_train | output | 1 | Stored link-training enable bit |
| ctl_xlat_en | output | 1 | Stored translation enable bit |

## Verification
A register write takes effect at the rising edge where `reg_we` is sampled. Read data is combinational, so the bench drives the write on a falling edge and then reads back a short delay after the next falling edge. A request driven on a falling edge is registered at the following rising edge, so its result is sampled on the falling edge after that, exactly one cycle later. One further falling edge with `lcl_valid` low checks that `out_valid` drops. Expected addresses come from a model of the requirements that uses shadow copies of the values the bench itself wrote.

// File: rtl/ob_win_pkg.sv
package ob_win_pkg;
  localparam int REG_W      = 32;
  localparam int RADDR_W    = 2 * REG_W;
  localparam int MB_SHIFT   = 20;
  localparam int CODE_W     = 3;
  localparam logic [11:0] OFS_CTRL = 12'h004;
  localparam logic [11:0] OFS_SIZE = 12'h010;
  localparam logic [11:0] OFS_WIN  = 12'h200;

  typedef struct packed {
    logic [REG_W-1:0] hi;
    logic [REG_W-1:0] lo;
  } win_entry_t;
endpackage

// File: rtl/ob_win_regs.sv
module ob_win_regs
  import ob_win_pkg::*;
#(
  parameter int NUM_WIN  = 4,
  parameter int SIZE_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [1:0]        ctrl_o,
  output logic [CODE_W-1:0] code_o,
  output win_entry_t        win_o [NUM_WIN]
);
  logic [1:0]        ctrl_q, ctrl_d;
  logic [CODE_W-1:0] code_q, code_d;
  win_entry_t        win_q [NUM_WIN];
  win_entry_t        win_d [NUM_WIN];

  always_comb begin
    ctrl_d = ctrl_q;
    code_d = code_q;
    if (reg_we && reg_addr == OFS_CTRL) ctrl_d = reg_wdata[1:0];
    if (reg_we && reg_addr == OFS_SIZE) code_d = reg_wdata[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      code_q <= CODE_W'(SIZE_RST);
    end else if (reg_we) begin
      ctrl_q <= ctrl_d;
      code_q <= code_d;
    end
  end

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    localparam logic [11:0] LO_OFS = OFS_WIN + 12'(8 * n);
    localparam logic [11:0] HI_OFS = LO_OFS + 12'h004;
    always_comb begin
      win_d[n] = win_q[n];
      if (reg_addr == LO_OFS) win_d[n].lo = reg_wdata;
      if (reg_addr == HI_OFS) win_d[n].hi = reg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_q[n] <= '0;
      else if (reg_we) win_q[n] <= win_d[n];
    end
    assign win_o[n] = win_q[n];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTRL) reg_rdata = {{(REG_W-2){1'b0}}, ctrl_q};
    if (reg_addr == OFS_SIZE) reg_rdata = {{(REG_W-CODE_W){1'b0}}, code_q};
    for (int n = 0; n < NUM_WIN; n++) begin
      if (reg_addr == OFS_WIN + 12'(8 * n))         reg_rdata = win_q[n].lo;
      if (reg_addr == OFS_WIN + 12'(8 * n) + 12'h4) reg_rdata = win_q[n].hi;
    end
  end

  assign ctrl_o = ctrl_q;
  assign code_o = code_q;
endmodule

// File: rtl/ob_win_select.sv
module ob_win_select
  import ob_win_pkg::*;
#(
  parameter int          LA_W        = 32,
  parameter int          NUM_WIN     = 4,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  localparam int         IDX_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [LA_W-1:0]   addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              in_range_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LA_W-1:0]   offset_o
);
  localparam logic [LA_W-1:0] BASE = LA_W'(REGION_BASE);

  logic [LA_W-1:0] diff;
  logic [LA_W-1:0] idx_full;
  logic [LA_W-1:0] low_mask;
  logic [5:0]      shamt;

  always_comb begin
    diff       = addr_i - BASE;
    shamt      = 6'(MB_SHIFT) + 6'(code_i);
    idx_full   = diff >> shamt;
    low_mask   = ~({LA_W{1'b1}} << shamt);
    offset_o   = diff & low_mask;
    in_range_o = (addr_i >= BASE) && (idx_full < LA_W'(NUM_WIN));
    idx_o      = idx_full[IDX_W-1:0];
  end
endmodule

// File: rtl/ob_win_stage.sv
module ob_win_stage
  import ob_win_pkg::*;
#(
  parameter int  LA_W    = 32,
  parameter int  NUM_WIN = 4,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LA_W-1:0]    req_addr,
  input  logic               xlat_en,
  input  logic               in_range,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LA_W-1:0]    offset,
  input  win_entry_t         win_i [NUM_WIN],
  output logic               out_valid,
  output logic [RADDR_W-1:0] out_addr,
  output logic               out_miss
);
  win_entry_t         sel;
  logic               hit;
  logic [RADDR_W-1:0] addr_d;
  logic               miss_d;

  always_comb begin
    sel = win_i[idx];
    hit = in_range && sel.lo[0];
    if (xlat_en && hit) begin
      addr_d = {sel.hi, sel.lo[REG_W-1:1], 1'b0} + RADDR_W'(offset);
      miss_d = 1'b0;
    end else begin
      addr_d = RADDR_W'(req_addr);
      miss_d = xlat_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_miss <= 1'b0;
    end else if (req_valid) begin
      out_addr <= addr_d;
      out_miss <= miss_d;
    end
  end
endmodule

// File: rtl/ob_win_xlate.sv
module ob_win_xlate
  import ob_win_pkg::*;
#(
  parameter int          LA_W        = 32,
  parameter int          NUM_WIN     = 4,
  parameter int          SIZE_RST    = 3,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [11:0]        reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               lcl_valid,
  input  logic [LA_W-1:0]    lcl_addr,
  output logic               out_valid,
  output logic [RADDR_W-1:0] out_addr,
  output logic               out_miss,
  output logic               ctl_link_train,
  output logic               ctl_xlat_en
);
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [1:0]        ctrl;
  logic [CODE_W-1:0] code;
  win_entry_t        win [NUM_WIN];
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [LA_W-1:0]   offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  ob_win_regs #(.NUM_WIN(NUM_WIN), .SIZE_RST(SIZE_RST)) regs_i (
    .clk(clk), .rst_n(rst_q_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_o(ctrl),
    .code_o(code), .win_o(win)
  );

  ob_win_select #(.LA_W(LA_W), .NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) sel_i (
    .addr_i(lcl_addr), .code_i(code), .in_range_o(in_range),
    .idx_o(idx), .offset_o(offset)
  );

  ob_win_stage #(.LA_W(LA_W), .NUM_WIN(NUM_WIN)) stage_i (
    .clk(clk), .rst_n(rst_q_n), .req_valid(lcl_valid), .req_addr(lcl_addr),
    .xlat_en(ctrl[1]), .in_range(in_range), .idx(idx), .offset(offset),
    .win_i(win), .out_valid(out_valid), .out_addr(out_addr), .out_miss(out_miss)
  );

  assign ctl_link_train = ctrl[0];
  assign ctl_xlat_en    = ctrl[1];
endmodule

// File: rtl/ob_win_xlate_chk.sv
module ob_win_xlate_chk #(
  parameter int          LA_W        = 32,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            lcl_valid,
  input logic [LA_W-1:0] lcl_addr,
  input logic            ctl_xlat_en,
  input logic            out_valid,
  input logic [63:0]     out_addr,
  input logic            out_miss
);
  // R9: result valid exactly one cycle after request
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == $past(lcl_valid));

  // R8: translation off never flags a miss
  p_off_no_miss_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !$past(ctl_xlat_en)) |-> !out_miss);

  // R8: translation off passes the address unchanged
  p_off_passthru_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !$past(ctl_xlat_en)) |-> out_addr == 64'($past(lcl_addr)));

  // R6 / R7: any miss returns the original address
  p_miss_passthru_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && out_miss) |-> out_addr == 64'($past(lcl_addr)));

  // R7: below the region is always a miss when enabled
  p_below_miss_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && $past(ctl_xlat_en) && $past(lcl_addr) < LA_W'(REGION_BASE)) |-> out_miss);
endmodule

bind ob_win_xlate ob_win_xlate_chk #(.LA_W(LA_W), .REGION_BASE(REGION_BASE)) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .lcl_valid(lcl_valid), .lcl_addr(lcl_addr),
  .ctl_xlat_en(ctl_xlat_en), .out_valid(out_valid), .out_addr(out_addr),
  .out_miss(out_miss)
);

// File: tb/ob_win_xlate_tb_top.sv
`timescale 1ns/1ps
module ob_win_xlate_tb_top;
  localparam int          NW   = 4;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lcl_valid = 1'b0;
  logic [31:0] lcl_addr = '0;
  logic        out_valid;
  logic [63:0] out_addr;
  logic        out_miss;
  logic        ctl_link_train, ctl_xlat_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0]  sh_ctrl = '0;
  logic [2:0]  sh_code = 3'd3;
  logic [31:0] sh_lo [NW];
  logic [31:0] sh_hi [NW];

  always #2 clk = ~clk;

  ob_win_xlate #(.LA_W(32), .NUM_WIN(NW), .SIZE_RST(3), .REGION_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcl_valid(lcl_valid),
    .lcl_addr(lcl_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_miss(out_miss), .ctl_link_train(ctl_link_train), .ctl_xlat_en(ctl_xlat_en)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 12'h004) sh_ctrl = d[1:0];
    if (a == 12'h010) sh_code = d[2:0];
    for (int n = 0; n < NW; n++) begin
      if (a == 12'h200 + 12'(8*n)) sh_lo[n] = d;
      if (a == 12'h204 + 12'(8*n)) sh_hi[n] = d;
    end
  endtask

  task automatic rd_check(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  // expected result derived from the requirements and bench shadows
  task automatic model(logic [31:0] a, output logic [63:0] ea, output logic em);
    logic [31:0] diff, idx, ofs;
    int sh;
    ea = 64'(a); em = 1'b0;
    if (!sh_ctrl[1]) return;
    em = 1'b1;
    if (a < BASE) return;
    diff = a - BASE; sh = 20 + int'(sh_code);
    idx = diff >> sh; ofs = diff & ((32'd1 << sh) - 1);
    if (idx >= NW) return;
    if (!sh_lo[idx][0]) return;
    ea = {sh_hi[idx], sh_lo[idx] & 32'hFFFF_FFFE} + 64'(ofs);
    em = 1'b0;
  endtask

  task automatic xlate(string req, logic [31:0] a);
    logic [63:0] ea; logic em;
    model(a, ea, em);
    @(negedge clk);
    lcl_valid = 1'b1; lcl_addr = a;
    @(negedge clk);
    lcl_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " addr"}, out_addr, ea);
    check({req, " miss"}, 64'(out_miss), 64'(em));
  endtask

  task automatic t_reset();
    check("R1 out_valid", 64'(out_valid), 0);
    check("R1 link", 64'(ctl_link_train), 0);
    check("R1 xlat", 64'(ctl_xlat_en), 0);
    rd_check("R1 size", 12'h010, 32'd3);
    rd_check("R1 ctrl", 12'h004, 32'd0);
    for (int n = 0; n < NW; n++) begin
      rd_check("R1 win lo", 12'h200 + 12'(8*n), 32'd0);
      rd_check("R1 win hi", 12'h204 + 12'(8*n), 32'd0);
    end
  endtask

  task automatic t_regs();
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0001);
    wr(12'h208, 32'h9000_0000); wr(12'h20C, 32'h0000_0002);
    wr(12'h210, 32'hFFF0_0001); wr(12'h214, 32'h0000_0005);
    wr(12'h218, 32'h1234_0001); wr(12'h21C, 32'hCAFE_0000);
    for (int n = 0; n < NW; n++) begin
      rd_check("R2 lo", 12'h200 + 12'(8*n), sh_lo[n]);
      rd_check("R2 hi", 12'h204 + 12'(8*n), sh_hi[n]);
    end
    wr(12'h010, 32'hFFFF_FFFB);
    rd_check("R4 size bits", 12'h010, 32'd3);
    rd_check("R4 unmapped", 12'h100, 32'd0);
  endtask

  task automatic t_ctrl();
    wr(12'h004, 32'hFFFF_FFFD);
    rd_check("R3 ctrl read", 12'h004, 32'd1);
    check("R3 link", 64'(ctl_link_train), 1);
    check("R3 xlat off", 64'(ctl_xlat_en), 0);
    wr(12'h004, 32'h0000_0002);
    check("R3 link off", 64'(ctl_link_train), 0);
    check("R3 xlat on", 64'(ctl_xlat_en), 1);
  endtask

  task automatic t_off();
    wr(12'h004, 32'h0);
    xlate("R8 in region", BASE + 32'h0000_1234);
    xlate("R8 below", 32'h1000_0000);
    xlate("R8 past end", BASE + 32'h0400_0000);
  endtask

  task automatic t_translate();
    wr(12'h004, 32'h2);
    xlate("R5 win0", BASE + 32'h0000_1234);
    xlate("R5 win0 top", BASE + 32'h007F_FFFF);
    xlate("R5 win3", BASE + 32'h0180_0010);
    check("R5 win3 value", out_addr, 64'hCAFE_0000_1234_0010);
  endtask

  task automatic t_disabled();
    xlate("R6 win1", BASE + 32'h0080_0040);
    check("R6 miss", 64'(out_miss), 1);
  endtask

  task automatic t_outside();
    xlate("R7 below", BASE - 32'd4);
    xlate("R7 past last", BASE + 32'h0200_0000);
    check("R7 miss", 64'(out_miss), 1);
  endtask

  task automatic t_carry();
    xlate("R10 carry", BASE + 32'h0120_0000);
    check("R10 value", out_addr, 64'h0000_0006_0010_0000);
  endtask

  task automatic t_resize();
    wr(12'h010, 32'd4);
    xlate("R11 16MB idx1", BASE + 32'h0180_0000);
    check("R11 now miss", 64'(out_miss), 1);
    xlate("R11 16MB idx3", BASE + 32'h0300_0000);
    check("R11 hit", 64'(out_miss), 0);
    wr(12'h010, 32'd3);
  endtask

  task automatic t_latency();
    @(negedge clk);
    lcl_valid = 1'b1; lcl_addr = BASE;
    #1;
    check("R9 not yet", 64'(out_valid), 0);
    @(negedge clk);
    lcl_valid = 1'b0;
    check("R9 one later", 64'(out_valid), 1);
    @(negedge clk);
    check("R9 drops", 64'(out_valid), 0);
  endtask

  initial begin
    for (int n = 0; n < NW; n++) begin sh_lo[n] = '0; sh_hi[n] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_regs();
    t_ctrl();
    t_off();
    t_translate();
    t_disabled();
    t_outside();
    t_carry();
    t_resize();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule